// File: doc/BRIEF.md
# Sticky Interrupt Collector

The block gathers a handful of synchronous hardware conditions into one register of latched event flags and drives a single active-high interrupt line. The conditions are four: converter over-range, clipping on any of several output channels, a vector of amplifier fault flags, and lock of the sample-rate converter. Each flag is set by a new rising edge of its condition, not by a level that is simply held. It then stays set until the host reads the event register. That read clears every flag at once.

Alongside the latched flags, the host can read the live value of every condition, the raw amplifier fault vector, and a mask register. A mask bit of 1 enables its source onto the interrupt line. The mask is the only writable state. It is cleared by reset, so every source starts out disabled.

The host side is a plain register port. A read strobe selects one of four word addresses and returns the word combinationally. A write enable with an address updates the mask. The fault-detection and clipping datapaths sit outside the block and appear here only as condition inputs.

Top module: `irq_collector`

## Requirements
- R1: A rising edge on a condition input (input high in a cycle where it was low in the previous cycle, or the first cycle after reset) sets that source's event bit at the next clock edge. The bit then holds until the event register is read. A falling edge sets nothing. Event bit positions are: 0 converter over-range, 1 channel clip, 2 amplifier fault, 3 converter lock.
- R2: A condition held high does not set its event bit again after a clearing read.
- R3: A read with the strobe at address 0 returns the event bits in bits 3:0 (upper bits zero) and clears all of them at that clock edge. Reads of other addresses, and address-0 reads without the strobe, clear nothing.
- R4: If a rising edge arrives in the same cycle as a clearing read, that source's event bit is set after the edge. The read still returns the pre-edge value, and all other bits are cleared.
- R5: `irq` is high exactly when some event bit and its mask bit (same position) are both 1. It falls in the cycle right after a clearing read.
- R6: After reset the event bits, the mask and `irq` are all zero.
- R7: A write with `wr_addr` = 2 loads the mask from `wr_data`. Writes to addresses 0, 1 and 3 leave it unchanged. Address 2 reads back the mask in bits 3:0, with zero above.
- R8: Address 1 returns the live conditions: bit 0 converter over-range, bit 1 converter lock, bits 2 and up the channel clip inputs (channel k at bit 2+k), and zero above.
- R9: A rising edge on any one of the channel clip inputs sets event bit 1.
- R10: Event bit 2 is set by a rising edge of any individual amplifier fault bit, including while another fault bit is already high. Address 3 returns the live fault vector in the low bits, with zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_ovr | input | 1 | Converter over-range condition |
| ch_clip | input | NCH | Per-channel clip conditions |
| amp_fault | input | NAMP | Amplifier fault flag vector |
| src_lock | input | 1 | Sample-rate converter lock condition |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 4 | Write data (mask bits) |
| rd_strobe | input | 1 | Read strobe; clears events when at address 0 |
| rd_addr | input | 2 | Read word address |
| rd_data | output | DW | Read data, combinational |
| irq | output | 1 | Active-high interrupt |

## Verification
The clearing read of the event register and a fresh rising edge of a condition can fall in the same clock cycle. The bench provokes this by leaving one source's flag pending, then raising a second source's condition in exactly the cycle that carries the clearing read. It judges the result from three observations: the returned word holds only the older flag, the pending flag is gone afterwards, and the new flag survives with `irq` high. Around this case, a sweep over every source and all sixteen mask values checks latching, level immunity, clearing and the interrupt equation.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 4;
  localparam int SRC_ADC   = 0;
  localparam int SRC_CHAN  = 1;
  localparam int SRC_AMP   = 2;
  localparam int SRC_LOCK  = 3;

  localparam logic [1:0] ADDR_EVT  = 2'd0;
  localparam logic [1:0] ADDR_LIVE = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;
  localparam logic [1:0] ADDR_AMP  = 2'd3;

  // next value of a latched flag: a new set wins over a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // interrupt line from flags and enables
  function automatic logic irq_reduce(input logic [NSRC-1:0] evt, input logic [NSRC-1:0] msk);
    return |(evt & msk);
  endfunction

  // live status word: over-range, lock, then channels
  function automatic logic [31:0] live_word(input logic adc, input logic lock, input logic [31:0] ch);
    return 32'(adc) | (32'(lock) << 1) | (ch << 2);
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= cond_i[i];
    end
    assign rise_o[i] = cond_i[i] & ~prev_q[i];

    // R2
    level_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i[i] && $past(cond_i[i]) && $past(rst_n)) |-> !rise_o[i]);
  end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic evt_o
);
  import irq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_o <= 1'b0;
    else        evt_o <= sticky_next(evt_o, set_i, clr_i);
  end

  // R1
  set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> evt_o);
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !clr_i) |=> evt_o);
  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !evt_o);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> evt_o);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NCH  = 3,
  parameter int NAMP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [NSRC-1:0] wr_data,
  input  logic            rd_strobe,
  input  logic [1:0]      rd_addr,
  input  logic [NSRC-1:0] evt_i,
  input  logic            adc_live,
  input  logic            lock_live,
  input  logic [NCH-1:0]  ch_live,
  input  logic [NAMP-1:0] amp_live,
  output logic [NSRC-1:0] mask_o,
  output logic            evt_clear_o,
  output logic [DW-1:0]   rd_data
);
  logic        mask_hit;
  logic [31:0] live32;

  assign mask_hit    = wr_en && (wr_addr == ADDR_MASK);
  assign evt_clear_o = rd_strobe && (rd_addr == ADDR_EVT);
  assign live32      = live_word(adc_live, lock_live, 32'(ch_live));

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_o <= '0;
    else if (mask_hit) mask_o <= wr_data;
  end

  always_comb begin
    case (rd_addr)
      ADDR_EVT:  rd_data = DW'(evt_i);
      ADDR_LIVE: rd_data = live32[DW-1:0];
      ADDR_MASK: rd_data = DW'(mask_o);
      default:   rd_data = DW'(amp_live);
    endcase
  end

  // R7
  mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_MASK) |=> $stable(mask_o));
  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_MASK) |=> (mask_o == $past(wr_data)));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NCH  = 3,
  parameter int NAMP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adc_ovr,
  input  logic [NCH-1:0]  ch_clip,
  input  logic [NAMP-1:0] amp_fault,
  input  logic            src_lock,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [NSRC-1:0] wr_data,
  input  logic            rd_strobe,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            irq
);
  localparam int NCOND = 2 + NCH + NAMP;
  localparam int CH_LO = 1;
  localparam int AM_LO = 1 + NCH;
  localparam int LK_AT = 1 + NCH + NAMP;

  logic [NCOND-1:0] cond_vec, rise_vec;
  logic [NCH-1:0]   ch_rise;
  logic [NAMP-1:0]  amp_rise;
  logic [NSRC-1:0]  src_rise, evt, mask;
  logic             evt_clear;

  assign cond_vec = {src_lock, amp_fault, ch_clip, adc_ovr};

  irq_edge_det #(.W(NCOND)) u_edge (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_vec), .rise_o(rise_vec)
  );

  assign ch_rise  = rise_vec[CH_LO +: NCH];
  assign amp_rise = rise_vec[AM_LO +: NAMP];

  assign src_rise[SRC_ADC]  = rise_vec[0];
  assign src_rise[SRC_CHAN] = |ch_rise;
  assign src_rise[SRC_AMP]  = |amp_rise;
  assign src_rise[SRC_LOCK] = rise_vec[LK_AT];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(src_rise[s]), .clr_i(evt_clear), .evt_o(evt[s])
    );

    // R5
    rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rise[s] && mask[s] && !wr_en) |=> irq);
  end

  irq_regfile #(.DW(DW), .NCH(NCH), .NAMP(NAMP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .evt_i(evt), .adc_live(adc_ovr), .lock_live(src_lock),
    .ch_live(ch_clip), .amp_live(amp_fault),
    .mask_o(mask), .evt_clear_o(evt_clear), .rd_data(rd_data)
  );

  assign irq = irq_reduce(evt, mask);

  // R5
  mask_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  // R5
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clear && src_rise == '0) |=> !irq);
  // R9
  chan_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_rise) |=> evt[SRC_CHAN]);
  // R10
  amp_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|amp_rise) |=> evt[SRC_AMP]);
endmodule

// File: tb/test_irq_collector.sv
module test_irq_collector;
  localparam int DW = 8, NCH = 3, NAMP = 4;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            adc_ovr = 1'b0, src_lock = 1'b0;
  logic [NCH-1:0]  ch_clip = '0;
  logic [NAMP-1:0] amp_fault = '0;
  logic            wr_en = 1'b0, rd_strobe = 1'b0;
  logic [1:0]      wr_addr = '0, rd_addr = '0;
  logic [3:0]      wr_data = '0;
  logic [DW-1:0]   rd_data;
  logic            irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] got;

  always #2 clk = ~clk;

  irq_collector #(.DW(DW), .NCH(NCH), .NAMP(NAMP)) i_irq_collector (
    .clk(clk), .rst_n(rst_n), .adc_ovr(adc_ovr), .ch_clip(ch_clip),
    .amp_fault(amp_fault), .src_lock(src_lock), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    rd_strobe = 1'b0; rd_addr = a; #1; v = 32'(rd_data);
  endtask

  task automatic strobe_read(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; rd_strobe = 1'b1; #1; v = 32'(rd_data);
    step(); rd_strobe = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [3:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    step(); wr_en = 1'b0;
  endtask

  task automatic drive_src(input int s, input int idx, input logic v);
    case (s)
      0: adc_ovr = v;
      1: ch_clip[idx] = v;
      2: amp_fault[idx] = v;
      default: src_lock = v;
    endcase
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst_n = 1'b1; step();

    // R6 reset state
    peek(2'd0, v); check("R6 events", v, 0);
    peek(2'd2, v); check("R6 mask", v, 0);
    check("R6 irq", 32'(irq), 0);

    // R7 mask sweep, stray addresses ignored
    for (int m = 0; m < 16; m++) begin
      do_write(2'd2, 4'(m));
      peek(2'd2, v); check("R7 mask load", v, m);
      for (int a = 0; a < 4; a++) begin
        if (a == 2) continue;
        do_write(2'(a), 4'(~m));
        peek(2'd2, v); check("R7 stray write", v, m);
      end
    end

    // R1 R2 R3 R5 R8 R9 R10 sweep over source and mask
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 16; m++) begin
        int idx;
        logic [31:0] live_exp;
        idx = (s == 1) ? (m % NCH) : (m % NAMP);
        do_write(2'd2, 4'(m));
        strobe_read(2'd0, v);
        drive_src(s, idx, 1'b1);
        step();
        peek(2'd0, v); check("R1 latch", v, 32'(1) << s);
        check("R5 irq", 32'(irq), 32'((m >> s) & 1));
        live_exp = (s == 0) ? 1 : (s == 1) ? (32'(1) << (2 + idx)) : (s == 3) ? 2 : 0;
        peek(2'd1, v); check("R8 live", v, live_exp);
        peek(2'd3, v); check("R10 amp live", v, (s == 2) ? (32'(1) << idx) : 0);
        strobe_read(2'd1, v); strobe_read(2'd3, v);
        peek(2'd0, v); check("R3 other reads keep", v, 32'(1) << s);
        strobe_read(2'd0, v); check("R3 read value", v, 32'(1) << s);
        peek(2'd0, v); check("R2 held level no reset", v, 0);
        check("R5 irq drop", 32'(irq), 0);
        drive_src(s, idx, 1'b0); step();
        peek(2'd0, v); check("R1 fall no event", v, 0);
      end
    end

    // R9 each channel alone
    for (int c = 0; c < NCH; c++) begin
      ch_clip[c] = 1'b1; step();
      strobe_read(2'd0, v); check("R9 channel", v, 2);
      ch_clip[c] = 1'b0; step();
    end

    // R10 second fault bit rises while first held
    amp_fault[0] = 1'b1; step();
    strobe_read(2'd0, v); check("R10 first fault", v, 4);
    amp_fault[2] = 1'b1; step();
    peek(2'd0, v); check("R10 second fault", v, 4);
    amp_fault = '0; step();

    // R4 rising edge coincident with clearing read
    do_write(2'd2, 4'b0001);
    strobe_read(2'd0, v);
    src_lock = 1'b1; step();
    rd_addr = 2'd0; rd_strobe = 1'b1; adc_ovr = 1'b1; #1;
    check("R4 read returns old", 32'(rd_data), 8);
    step(); rd_strobe = 1'b0;
    peek(2'd0, v); check("R4 new edge kept", v, 1);
    check("R4 irq", 32'(irq), 1);
    adc_ovr = 1'b0; src_lock = 1'b0;
    strobe_read(2'd0, v);

    // R3 un-strobed address-0 look does not clear
    src_lock = 1'b1; step();
    peek(2'd0, v); step(); peek(2'd0, v);
    check("R3 no strobe no clear", v, 8);
    src_lock = 1'b0; step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule